// File: doc/BRIEF.md
# Line Access Switch State Sequencer

This block drives the ten contact enables of a line-card access switch matrix. Software or a line controller asks for one of eight operating states through a 3-bit code. The block turns that code into a fixed set of closed contacts. It also controls the order in which contacts change, so that two contact groups are never closed together by accident. The only exception is the ringing-to-talk handover, and there a mode input selects one of two orderings. In one ordering the talk pair closes before the ringing pair opens. In the other the ringing pair opens first and a gap follows before the talk pair closes.

Two protective inputs override the requested state. A force-off input opens every contact at once, without waiting for a clock. After it is asserted, the block holds the matrix open for a timed interval, and this hold can serve as a slow break-before-make handover. A battery-present input opens every contact whenever it is low. After reset or a battery dropout, the block sits in all-off until the battery is present and then enters talk. A busy output shows that a sequence is running. Requests that arrive meanwhile are latched and served once the sequence ends.

The request, mode and variant inputs are plain control levels sampled on the clock. No data stream passes through the block, so it has no valid/ready handshake.

Top module: `line_switch_seq`

## Requirements
- R1: State codes map to contact enables: 0 all open; 1 talk closes sw_en[1:0]; 2 ringing closes sw_en[3:2]; 3 loop access closes sw_en[5:4]; 4 ring-generator test closes sw_en[7:6]; 5 SLIC test closes sw_en[9:8]. Every other bit is 0.
- R2: Code 6 closes sw_en[5:4] and sw_en[9:8]. Code 7 closes sw_en[7:4].
- R3: A change of state other than ringing to talk is seen two cycles after the request: one cycle with sw_en all zero, then the new set on the next cycle. A request equal to the current state changes nothing.
- R4: With make_first=1, the ringing-to-talk change shows sw_en[3:0]=1111 for GAP_CYC cycles and then the talk set.
- R5: With make_first=0, the ringing-to-talk change shows sw_en all zero for GAP_CYC cycles and then the talk set.
- R6: While force_off is high, sw_en is all zero, with no clock edge needed.
- R7: Once force_off has been seen high, the contacts stay open for CLK_HZ/1000*HOLD_MS cycles and for as long as force_off stays high. The block then applies the latched request directly. With a 2-stage input synchronizer, the new set appears on the (HOLD+3)th rising edge after force_off rises, provided force_off has already fallen.
- R8: While batt_ok is low, sw_en is all zero. On the first edge with batt_ok high again, the block enters talk. It then serves any pending different request as in R3.
- R9: When has_combo_test=0, request code 7 is ignored and the contacts keep their current set.
- R10: busy is high during the all-off step, the handover window, the force hold and the wait for battery, and low otherwise. A request made while busy is served once the sequence completes.
- R11: During reset sw_en is all zero and busy is high. After reset the block enters talk on the first edge with batt_ok high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_state | input | 3 | Requested state code (see R1, R2) |
| make_first | input | 1 | 1: close talk pair before opening ringing pair; 0: open first |
| has_combo_test | input | 1 | 1: variant supports state code 7 |
| force_off | input | 1 | Asynchronous force-all-open request |
| batt_ok | input | 1 | Battery present |
| sw_en | output | 10 | Contact enables, bit n drives contact n+1 |
| busy | output | 1 | Sequence in progress |

## Verification
The bench builds the block with CLK_HZ=100000, HOLD_MS=25 and GAP_CYC=3. The hold then lasts 2500 cycles, so the whole force-off window can be stepped cycle by cycle inside the run, and each edge of the handover window is checked. With these values the bench can sweep all 64 ordered pairs of source and destination state. It can also check both handover orderings with their exact edge positions, and it places a request in the middle of a handover.

// File: rtl/lsw_pkg.sv
package lsw_pkg;
  localparam int NSW = 10;

  typedef enum logic [2:0] {
    ST_OFF      = 3'd0,
    ST_TALK     = 3'd1,
    ST_RING     = 3'd2,
    ST_LOOP     = 3'd3,
    ST_RGTEST   = 3'd4,
    ST_SLTEST   = 3'd5,
    ST_LOOP_SLT = 3'd6,
    ST_OUT_RGT  = 3'd7
  } lsw_state_e;

  typedef enum logic [2:0] {
    PH_WAIT, PH_STEADY, PH_GAP, PH_MAKE, PH_BREAK, PH_HOLD
  } lsw_phase_e;

  localparam logic [NSW-1:0] SET_TALK = 10'b00_0000_0011;
  localparam logic [NSW-1:0] SET_RING = 10'b00_0000_1100;
  localparam logic [NSW-1:0] SET_OVL  = SET_TALK | SET_RING;
endpackage

// File: rtl/lsw_sync.sv
module lsw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;
  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
      end
    end
  endgenerate
  assign q = chain[STAGES-1];
endmodule

// File: rtl/lsw_req_latch.sv
module lsw_req_latch
  import lsw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] req_state,
  input  logic       has_combo_test,
  output lsw_state_e pend
);
  logic allowed;
  assign allowed = has_combo_test || (req_state != 3'(ST_OUT_RGT));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       pend <= ST_TALK;
    else if (allowed) pend <= lsw_state_e'(req_state);
endmodule

// File: rtl/lsw_pattern.sv
module lsw_pattern
  import lsw_pkg::*;
(
  input  lsw_state_e       st,
  output logic [NSW-1:0]   pat
);
  always_comb begin
    pat = '0;
    case (st)
      ST_TALK:     pat[1:0] = 2'b11;
      ST_RING:     pat[3:2] = 2'b11;
      ST_LOOP:     pat[5:4] = 2'b11;
      ST_RGTEST:   pat[7:6] = 2'b11;
      ST_SLTEST:   pat[9:8] = 2'b11;
      ST_LOOP_SLT: begin pat[5:4] = 2'b11; pat[9:8] = 2'b11; end
      ST_OUT_RGT:  pat[7:4] = 4'b1111;
      default:     pat = '0;
    endcase
  end
endmodule

// File: rtl/line_switch_seq.sv
module line_switch_seq
  import lsw_pkg::*;
#(
  parameter int CLK_HZ  = 125_000_000,
  parameter int HOLD_MS = 25,
  parameter int GAP_CYC = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  req_state,
  input  logic        make_first,
  input  logic        has_combo_test,
  input  logic        force_off,
  input  logic        batt_ok,
  output logic [9:0]  sw_en,
  output logic        busy
);
  localparam int HOLD_CYC = CLK_HZ / 1000 * HOLD_MS;
  localparam int CNT_MAX  = (HOLD_CYC > GAP_CYC) ? HOLD_CYC : GAP_CYC;
  localparam int CW       = $clog2(CNT_MAX + 1);
  localparam logic [CW-1:0] HOLD_LD = CW'(HOLD_CYC - 1);
  localparam logic [CW-1:0] GAP_LD  = CW'(GAP_CYC - 1);

  lsw_phase_e       ph_q;
  lsw_state_e       cur_q, tgt_q, pend, apply_st;
  logic [CW-1:0]    cnt_q;
  logic [NSW-1:0]   pat_q, apply_pat;
  logic             force_s;

  lsw_sync #(.STAGES(2)) u_fsync (
    .clk(clk), .rst_n(rst_n), .d(force_off), .q(force_s)
  );

  lsw_req_latch u_req (
    .clk(clk), .rst_n(rst_n), .req_state(req_state),
    .has_combo_test(has_combo_test), .pend(pend)
  );

  always_comb begin
    case (ph_q)
      PH_GAP:  apply_st = tgt_q;
      PH_HOLD: apply_st = pend;
      default: apply_st = ST_TALK;
    endcase
  end

  lsw_pattern u_pat (.st(apply_st), .pat(apply_pat));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_WAIT;
      cur_q <= ST_OFF;
      tgt_q <= ST_OFF;
      cnt_q <= '0;
      pat_q <= '0;
    end else if (!batt_ok) begin
      ph_q  <= PH_WAIT;
      cur_q <= ST_OFF;
      pat_q <= '0;
    end else if (force_s && ph_q != PH_WAIT && ph_q != PH_HOLD) begin
      ph_q  <= PH_HOLD;
      cur_q <= ST_OFF;
      cnt_q <= HOLD_LD;
      pat_q <= '0;
    end else begin
      case (ph_q)
        PH_WAIT: begin
          ph_q  <= PH_STEADY;
          cur_q <= ST_TALK;
          pat_q <= apply_pat;
        end
        PH_STEADY: begin
          if (pend != cur_q) begin
            if (cur_q == ST_RING && pend == ST_TALK) begin
              ph_q  <= make_first ? PH_MAKE : PH_BREAK;
              pat_q <= make_first ? SET_OVL : '0;
              cnt_q <= GAP_LD;
            end else begin
              ph_q  <= PH_GAP;
              tgt_q <= pend;
              pat_q <= '0;
            end
          end
        end
        PH_GAP: begin
          ph_q  <= PH_STEADY;
          cur_q <= tgt_q;
          pat_q <= apply_pat;
        end
        PH_MAKE, PH_BREAK: begin
          if (cnt_q == '0) begin
            ph_q  <= PH_STEADY;
            cur_q <= ST_TALK;
            pat_q <= apply_pat;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        PH_HOLD: begin
          if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
          end else if (!force_s) begin
            ph_q  <= PH_STEADY;
            cur_q <= pend;
            pat_q <= apply_pat;
          end
        end
        default: ph_q <= PH_WAIT;
      endcase
    end
  end

  assign sw_en = (force_off || !batt_ok) ? '0 : pat_q;
  assign busy  = (ph_q != PH_STEADY);
endmodule

// File: rtl/lsw_checker.sv
module lsw_checker
  import lsw_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       force_off,
  input logic       batt_ok,
  input logic [9:0] sw_en,
  input logic       busy
);
  // R6: force request leaves every contact open
  a_r6_force_opens: assert property (@(posedge clk) disable iff (!rst_n)
    force_off |-> sw_en == '0);

  // R8: missing battery leaves every contact open
  a_r8_batt_opens: assert property (@(posedge clk) disable iff (!rst_n)
    !batt_ok |-> sw_en == '0);

  // R10: while busy only all-open or the handover overlap may appear
  a_r10_busy_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && sw_en != '0) |-> sw_en == SET_OVL);

  // R3: one nonzero set changes directly into another only along the make-first handover
  a_r3_direct_change: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sw_en) != '0 && sw_en != '0 && sw_en != $past(sw_en)) |->
      (($past(sw_en) == SET_RING && sw_en == SET_OVL) ||
       ($past(sw_en) == SET_OVL  && sw_en == SET_TALK)));

  // R1: a settled set is one legal state pattern
  a_r1_settled_legal: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (($countones(sw_en) inside {0, 2, 4}) && sw_en != SET_OVL));
endmodule

bind line_switch_seq lsw_checker u_chk (
  .clk(clk), .rst_n(rst_n), .force_off(force_off),
  .batt_ok(batt_ok), .sw_en(sw_en), .busy(busy)
);

// File: tb/sim_line_switch_seq.sv
module sim_line_switch_seq;
  localparam int CLK_HZ = 100_000;
  localparam int HOLD_MS = 25;
  localparam int G = 3;
  localparam int H = CLK_HZ / 1000 * HOLD_MS;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] req_state = 3'd1;
  logic make_first = 1'b1, has_combo_test = 1'b1;
  logic force_off = 1'b0, batt_ok = 1'b0;
  logic [9:0] sw_en;
  logic busy;
  int errors = 0, checks = 0, cur_m = 1;
  bit done = 0;

  line_switch_seq #(.CLK_HZ(CLK_HZ), .HOLD_MS(HOLD_MS), .GAP_CYC(G)) u0 (
    .clk(clk), .rst_n(rst_n), .req_state(req_state), .make_first(make_first),
    .has_combo_test(has_combo_test), .force_off(force_off), .batt_ok(batt_ok),
    .sw_en(sw_en), .busy(busy)
  );

  always #4 clk = ~clk;

  function automatic logic [9:0] exp_pat(input int s);
    if (s == 0) return 10'd0;
    if (s <= 5) return 10'(3 << (2 * (s - 1)));
    if (s == 6) return 10'((3 << 4) | (3 << 8));
    return 10'(15 << 4);
  endfunction

  task automatic chk(input string r, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s sw_en actual=%b expected=%b", r, act, exp);
    end
  endtask

  task automatic chkb(input string r, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s busy actual=%b expected=%b", r, act, exp);
    end
  endtask

  task automatic move(input int dst);
    @(negedge clk); req_state = 3'(dst);
    @(negedge clk);
    if (dst == cur_m) begin
      @(negedge clk);
      chk("R3", sw_en, exp_pat(cur_m)); chkb("R3", busy, 1'b0);
    end else if (cur_m == 2 && dst == 1) begin
      for (int i = 0; i < G; i++) begin
        @(negedge clk);
        chk(make_first ? "R4" : "R5", sw_en, make_first ? 10'b1111 : 10'b0);
        chkb("R10", busy, 1'b1);
      end
      @(negedge clk);
      chk(make_first ? "R4" : "R5", sw_en, exp_pat(1)); chkb("R10", busy, 1'b0);
    end else begin
      @(negedge clk);
      chk("R3", sw_en, 10'b0); chkb("R10", busy, 1'b1);
      @(negedge clk);
      chk(dst <= 5 ? "R1" : "R2", sw_en, exp_pat(dst)); chkb("R10", busy, 1'b0);
    end
    cur_m = dst;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R11: reset state, then wait for battery
    #2;
    chk("R11", sw_en, 10'b0); chkb("R11", busy, 1'b1);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) begin
      @(negedge clk); chk("R11", sw_en, 10'b0); chkb("R11", busy, 1'b1);
    end
    batt_ok = 1'b1;
    @(negedge clk); chk("R11", sw_en, exp_pat(1)); chkb("R11", busy, 1'b0);
    cur_m = 1;

    // R1 R2 R3: every ordered pair of states
    for (int a = 0; a < 8; a++)
      for (int b = 0; b < 8; b++) begin
        make_first = ((a + b) % 2) == 1;
        move(a); move(b);
      end

    // R4 and R5: both handover orders
    make_first = 1'b1; move(2); move(1);
    make_first = 1'b0; move(2); move(1);

    // R10: request during the handover waits for completion
    make_first = 1'b1; move(2);
    @(negedge clk); req_state = 3'd1;
    for (int n = 1; n <= 7; n++) begin
      @(negedge clk);
      if (n == 2) req_state = 3'd3;
      if (n == 5) begin chk("R10", sw_en, exp_pat(1)); chkb("R10", busy, 1'b0); end
      if (n == 6) begin chk("R10", sw_en, 10'b0); chkb("R10", busy, 1'b1); end
      if (n == 7) begin chk("R10", sw_en, exp_pat(3)); chkb("R10", busy, 1'b0); end
    end
    cur_m = 3;

    // R6 R7: force-off hold as a slow break-first handover
    move(2);
    @(negedge clk); force_off = 1'b1; req_state = 3'd1;
    #1 chk("R6", sw_en, 10'b0);
    for (int k = 1; k <= H + 3; k++) begin
      @(negedge clk);
      if (k == 10) force_off = 1'b0;
      if (k == 20) begin chk("R7", sw_en, 10'b0); chkb("R7", busy, 1'b1); end
      if (k == H + 2) begin chk("R7", sw_en, 10'b0); chkb("R7", busy, 1'b1); end
      if (k == H + 3) begin chk("R7", sw_en, exp_pat(1)); chkb("R7", busy, 1'b0); end
    end
    cur_m = 1;

    // R8: battery dropout and recovery
    move(4);
    @(negedge clk); batt_ok = 1'b0;
    #1 chk("R8", sw_en, 10'b0);
    @(negedge clk); chkb("R8", busy, 1'b1);
    repeat (3) @(negedge clk);
    batt_ok = 1'b1;
    @(negedge clk); chk("R8", sw_en, exp_pat(1));
    @(negedge clk); chk("R8", sw_en, 10'b0);
    @(negedge clk); chk("R8", sw_en, exp_pat(4));
    cur_m = 4;

    // R9: code 7 ignored on a variant without it
    move(1);
    @(negedge clk); has_combo_test = 1'b0; req_state = 3'd7;
    repeat (4) begin
      @(negedge clk); chk("R9", sw_en, exp_pat(1)); chkb("R9", busy, 1'b0);
    end
    req_state = 3'd1;
    @(negedge clk); has_combo_test = 1'b1;
    @(negedge clk); chk("R9", sw_en, exp_pat(1));

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule